// File: doc/BRIEF.md
# Indexed Gain-Offset Calibration Stage

This block sits in the sample stream just ahead of a DAC and applies the base calibration layer to every sample: a gain multiply followed by an offset add, with the result clipped to the signed output range. The coefficients are not one fixed pair. The block holds a table of coefficient sets and picks one for each sample from three selectors that travel with that sample: the output range, the temperature bucket and the band/mode (interpolation or filter setting). Each set also holds a calibration version tag. The tag of the set used for a sample comes out beside that sample.

A host loads coefficients through a small write port into a shadow table. A single commit strobe copies the whole shadow table into the active table in one clock edge, so a sample never sees a mix of old and new values. A correction-enable input sends samples through unchanged when it is low. The pipeline depth is the same whether correction is on or off.

Top module: `idxcal_stage`

## Requirements
- R1: After reset the output valid, data and version outputs are 0, and every coefficient set is gain 16384 (unity), offset 0, version 0, so corrected samples pass unchanged.
- R2: With correction enabled, the output is floor((x*G + 8192) / 16384) + O. Here x is the signed 16-bit input, G is the unsigned Q2.14 gain and O is the signed 16-bit offset.
- R3: The corrected result is clipped to the range -32768..32767 and never wraps. A non-negative input with a non-negative offset never gives a negative output. A negative input with a negative offset always gives a negative output.
- R4: The set index is {range[1:0], bucket[1:0], mode[0]}, that is range*8 + bucket*2 + mode. Each of the 32 sets is independent.
- R5: A host write (cfg_we_i) changes only the shadow copy. The output is unaffected until a commit.
- R6: A commit strobe copies all shadow sets into the active table at one edge. A sample presented in the same cycle as the strobe uses the old values. The next sample uses the new values.
- R7: The selectors are sampled together with each input sample. Back-to-back samples with different selectors each use their own set, and gain, offset and version of that set all apply to the same sample.
- R8: With correction disabled, the output equals the input exactly.
- R9: Output valid follows input valid by exactly 2 cycles, in both corrected and bypass modes.
- R10: ver_o carries the version tag of the set selected for the sample on smp_data_o, whether correction is on or off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_valid_i | input | 1 | Input sample valid |
| smp_data_i | input | 16 | Signed input sample |
| rng_i | input | 2 | Output range selector |
| tbk_i | input | 2 | Temperature bucket selector |
| mode_i | input | 1 | Band/mode selector |
| corr_en_i | input | 1 | 1 = apply correction, 0 = pass through |
| cfg_we_i | input | 1 | Write one shadow set |
| cfg_set_i | input | 5 | Shadow set index written |
| cfg_gain_i | input | 16 | Gain, unsigned Q2.14 |
| cfg_offset_i | input | 16 | Offset, signed |
| cfg_ver_i | input | 8 | Version tag for the set |
| cfg_commit_i | input | 1 | Copy shadow table into active table |
| smp_valid_o | output | 1 | Output sample valid |
| smp_data_o | output | 16 | Corrected or passed sample |
| ver_o | output | 8 | Version tag of the set used |

## Verification
The hardest case to reach is a commit strobe that lands in the same cycle as a sample, with the next sample close behind. Only that case shows whether the table switch is atomic at a sample boundary. The stimulus stages a differing shadow entry, raises the strobe together with one sample, and follows it at once with a second sample on the same selectors. It then expects the old version tag and result on the first sample and the new ones on the second. Back-to-back samples with changing selectors, and products pushed past both ends of the range, cover the other corners.

// File: rtl/idxcal_pkg.sv
package idxcal_pkg;

    localparam int DW   = 16;
    localparam int GW   = 16;
    localparam int OW   = 16;
    localparam int VW   = 8;
    localparam int FRAC = 14;

    typedef struct packed {
        logic [GW-1:0]        gain;
        logic signed [OW-1:0] offset;
        logic [VW-1:0]        ver;
    } coef_t;

    localparam coef_t COEF_UNITY = '{gain: GW'(1 << FRAC), offset: '0, ver: '0};

    typedef struct packed {
        logic                 valid;
        logic                 en;
        logic signed [DW-1:0] data;
        coef_t                coef;
    } stg1_t;

    typedef struct packed {
        logic                 valid;
        logic signed [DW-1:0] data;
        logic [VW-1:0]        ver;
    } outs_t;

endpackage

// File: rtl/idxcal_coef_bank.sv
module idxcal_coef_bank
    import idxcal_pkg::*;
#(
    parameter int SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_set,
    input  coef_t            cfg_coef,
    input  logic             cfg_commit,
    input  logic [SEL_W-1:0] rd_sel,
    output coef_t            rd_coef
);

    localparam int NSETS = 1 << SEL_W;

    coef_t shd_d [NSETS];
    coef_t shd_q [NSETS];
    coef_t act_d [NSETS];
    coef_t act_q [NSETS];

    always_comb begin
        shd_d = shd_q;
        act_d = act_q;
        if (cfg_commit) begin
            act_d = shd_q;
        end
        if (cfg_we) begin
            shd_d[cfg_set] = cfg_coef;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSETS; i++) begin
                shd_q[i] <= COEF_UNITY;
                act_q[i] <= COEF_UNITY;
            end
        end else begin
            shd_q <= shd_d;
            act_q <= act_d;
        end
    end

    assign rd_coef = act_q[rd_sel];

    for (genvar g = 0; g < NSETS; g++) begin : g_chk
        AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_commit |=> act_q[g] == $past(act_q[g]))
            else $error("active set changed without commit"); // R5
        AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_commit |=> act_q[g] == $past(shd_q[g]))
            else $error("commit did not copy shadow set"); // R6
    end

endmodule

// File: rtl/idxcal_datapath.sv
module idxcal_datapath
    import idxcal_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_en,
    input  logic signed [DW-1:0] in_data,
    input  coef_t                in_coef,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data,
    output logic [VW-1:0]        out_ver
);

    localparam int AW = 2 * DW + 2;
    localparam logic signed [AW-1:0] RND  = AW'(1 << (FRAC - 1));
    localparam logic signed [AW-1:0] MAXV = AW'((1 << (DW - 1)) - 1);
    localparam logic signed [AW-1:0] MINV = -AW'(1 << (DW - 1));

    typedef struct packed {
        stg1_t s1;
        outs_t o;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic signed [AW-1:0] xs, gs, prod, scaled, sum, clip;

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.s1.valid = in_valid;
        pipe_d.s1.en    = in_en;
        pipe_d.s1.data  = in_data;
        pipe_d.s1.coef  = in_coef;

        xs     = AW'(pipe_q.s1.data);
        gs     = AW'({1'b0, pipe_q.s1.coef.gain});
        prod   = xs * gs;
        scaled = (prod + RND) >>> FRAC;
        sum    = scaled + AW'(pipe_q.s1.coef.offset);
        if (sum > MAXV) begin
            clip = MAXV;
        end else if (sum < MINV) begin
            clip = MINV;
        end else begin
            clip = sum;
        end

        pipe_d.o.valid = pipe_q.s1.valid;
        pipe_d.o.data  = pipe_q.s1.en ? DW'(clip) : pipe_q.s1.data;
        pipe_d.o.ver   = pipe_q.s1.coef.ver;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.o.valid;
    assign out_data  = pipe_q.o.data;
    assign out_ver   = pipe_q.o.ver;

    AST_NO_WRAP_POS: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.s1.valid && pipe_q.s1.en && !pipe_q.s1.data[DW-1] && !pipe_q.s1.coef.offset[OW-1]
        |=> !pipe_q.o.data[DW-1])
        else $error("positive result wrapped negative"); // R3
    AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.s1.valid && pipe_q.s1.en && pipe_q.s1.data[DW-1] && pipe_q.s1.coef.offset[OW-1]
        |=> pipe_q.o.data[DW-1])
        else $error("negative result wrapped positive"); // R3

endmodule

// File: rtl/idxcal_stage.sv
module idxcal_stage
    import idxcal_pkg::*;
#(
    parameter int RNG_W  = 2,
    parameter int TBK_W  = 2,
    parameter int MODE_W = 1,
    localparam int SEL_W = RNG_W + TBK_W + MODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid_i,
    input  logic [DW-1:0]    smp_data_i,
    input  logic [RNG_W-1:0] rng_i,
    input  logic [TBK_W-1:0] tbk_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic             corr_en_i,
    input  logic             cfg_we_i,
    input  logic [SEL_W-1:0] cfg_set_i,
    input  logic [GW-1:0]    cfg_gain_i,
    input  logic [OW-1:0]    cfg_offset_i,
    input  logic [VW-1:0]    cfg_ver_i,
    input  logic             cfg_commit_i,
    output logic             smp_valid_o,
    output logic [DW-1:0]    smp_data_o,
    output logic [VW-1:0]    ver_o
);

    logic [SEL_W-1:0] sel;
    coef_t            wr_coef;
    coef_t            cur_coef;
    logic signed [DW-1:0] dp_out;

    assign sel     = {rng_i, tbk_i, mode_i};
    assign wr_coef = '{gain: cfg_gain_i, offset: cfg_offset_i, ver: cfg_ver_i};

    idxcal_coef_bank #(.SEL_W(SEL_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we_i),
        .cfg_set    (cfg_set_i),
        .cfg_coef   (wr_coef),
        .cfg_commit (cfg_commit_i),
        .rd_sel     (sel),
        .rd_coef    (cur_coef)
    );

    idxcal_datapath u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_valid_i),
        .in_en     (corr_en_i),
        .in_data   (smp_data_i),
        .in_coef   (cur_coef),
        .out_valid (smp_valid_o),
        .out_data  (dp_out),
        .out_ver   (ver_o)
    );

    assign smp_data_o = dp_out;

    logic [1:0] warm_d, warm_q;

    always_comb begin
        warm_d = (warm_q == 2'd2) ? warm_q : warm_q + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else begin
            warm_q <= warm_d;
        end
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q == 2'd2 |-> smp_valid_o == $past(smp_valid_i, 2))
        else $error("valid latency not two cycles"); // R9
    AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q == 2'd2 && smp_valid_o && !$past(corr_en_i, 2)
        |-> smp_data_o == $past(smp_data_i, 2))
        else $error("bypass altered sample"); // R8

endmodule

// File: tb/sim_idxcal_stage.sv
module sim_idxcal_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid_i = 1'b0;
    logic [15:0] smp_data_i = '0;
    logic [1:0]  rng_i = '0;
    logic [1:0]  tbk_i = '0;
    logic [0:0]  mode_i = '0;
    logic        corr_en_i = 1'b1;
    logic        cfg_we_i = 1'b0;
    logic [4:0]  cfg_set_i = '0;
    logic [15:0] cfg_gain_i = '0;
    logic [15:0] cfg_offset_i = '0;
    logic [7:0]  cfg_ver_i = '0;
    logic        cfg_commit_i = 1'b0;
    logic        smp_valid_o;
    logic [15:0] smp_data_o;
    logic [7:0]  ver_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    idxcal_stage u0 (
        .clk(clk), .rst_n(rst_n),
        .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
        .rng_i(rng_i), .tbk_i(tbk_i), .mode_i(mode_i), .corr_en_i(corr_en_i),
        .cfg_we_i(cfg_we_i), .cfg_set_i(cfg_set_i), .cfg_gain_i(cfg_gain_i),
        .cfg_offset_i(cfg_offset_i), .cfg_ver_i(cfg_ver_i), .cfg_commit_i(cfg_commit_i),
        .smp_valid_o(smp_valid_o), .smp_data_o(smp_data_o), .ver_o(ver_o)
    );

    // {rng, tbk, mode, en, x, expected data, expected version}
    localparam logic [45:0] VEC [0:13] = '{
        {2'd0, 2'd0, 1'd0, 1'b1,  16'sd1234,   16'sd1234,  8'h10},  // R4 unity set
        {2'd0, 2'd0, 1'd1, 1'b1,  16'sd1000,   16'sd600,   8'h11},  // R2 half gain
        {2'd0, 2'd0, 1'd1, 1'b1, -16'sd1001,  -16'sd400,   8'h11},  // R2 negative
        {2'd0, 2'd1, 1'd0, 1'b1,  16'sd300,    16'sd550,   8'h12},  // R4 bucket
        {2'd0, 2'd1, 1'd0, 1'b1,  16'sd20000,  16'sd32767, 8'h12},  // R3 high clip
        {2'd0, 2'd1, 1'd0, 1'b1, -16'sd20000, -16'sd32768, 8'h12},  // R3 low clip
        {2'd1, 2'd0, 1'd0, 1'b1,  16'sd1000,   16'sd1500,  8'h13},  // R4 range
        {2'd1, 2'd0, 1'd0, 1'b1, -16'sd3,     -16'sd4,     8'h13},  // R2 rounding
        {2'd3, 2'd3, 1'd1, 1'b1,  16'sd1,      16'sd32767, 8'h1F},  // R3 offset clip
        {2'd3, 2'd3, 1'd1, 1'b1, -16'sd32768, -16'sd32768, 8'h1F},  // R3 max gain
        {2'd0, 2'd1, 1'd0, 1'b0,  16'sd20000,  16'sd20000, 8'h12},  // R8 bypass
        {2'd3, 2'd3, 1'd1, 1'b0, -16'sd32768, -16'sd32768, 8'h1F},  // R8 bypass
        {2'd0, 2'd2, 1'd0, 1'b1, -16'sd7,     -16'sd7,     8'h00},  // R1 default set
        {2'd2, 2'd0, 1'd0, 1'b1,  16'sd32767,  16'sd32767, 8'h00}   // R1 default set
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] r, input logic [1:0] t, input logic m,
                         input logic en, input logic [15:0] x);
        smp_valid_i = 1'b1;
        rng_i = r; tbk_i = t; mode_i = m; corr_en_i = en; smp_data_i = x;
    endtask

    task automatic cfg_write(input int idx, input int g, input int o, input int v);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_set_i = 5'(idx);
        cfg_gain_i = 16'(g); cfg_offset_i = 16'(o); cfg_ver_i = 8'(v);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        cfg_commit_i = 1'b1;
        @(negedge clk);
        cfg_commit_i = 1'b0;
    endtask

    task automatic send_check(input string req, input logic [1:0] r, input logic [1:0] t,
                              input logic m, input logic en, input logic [15:0] x,
                              input logic [15:0] exp_d, input logic [7:0] exp_v);
        @(negedge clk);
        drive(r, t, m, en, x);
        @(negedge clk);
        smp_valid_i = 1'b0;
        @(negedge clk);
        chk({req, " valid"}, int'(smp_valid_o), 1);
        chk({req, " data"}, int'($signed(smp_data_o)), int'($signed(exp_d)));
        chk({req, " ver"}, int'(ver_o), int'(exp_v));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset valid", int'(smp_valid_o), 0);
        chk("R1 reset data", int'(smp_data_o), 0);
        chk("R1 reset ver", int'(ver_o), 0);
        rst_n = 1'b1;
        // R1: default unity set before any programming
        send_check("R1 default", 2'd0, 2'd2, 1'b1, 1'b1, 16'd77, 16'd77, 8'h00);

        cfg_write(0, 16384, 0, 'h10);
        cfg_write(1, 8192, 100, 'h11);
        cfg_write(2, 32768, -50, 'h12);
        cfg_write(8, 24576, 0, 'h13);
        cfg_write(31, 65535, 32767, 'h1F);
        commit();

        for (int i = 0; i < 14; i++) begin
            send_check($sformatf("R2/R3/R4/R8/R10 vec%0d", i), VEC[i][45:44], VEC[i][43:42],
                       VEC[i][41], VEC[i][40], VEC[i][39:24], VEC[i][23:8], VEC[i][7:0]);
        end

        // R5: shadow write alone leaves output unchanged
        cfg_write(0, 8192, 0, 'h20);
        send_check("R5 shadow only", 2'd0, 2'd0, 1'b0, 1'b1, 16'd1000, 16'd1000, 8'h10);
        commit();
        send_check("R6 after commit", 2'd0, 2'd0, 1'b0, 1'b1, 16'd1000, 16'd500, 8'h20);

        // R6: commit in the same cycle as a sample
        cfg_write(0, 16384, 0, 'h21);
        @(negedge clk);
        drive(2'd0, 2'd0, 1'b0, 1'b1, 16'd1000);
        cfg_commit_i = 1'b1;
        @(negedge clk);
        cfg_commit_i = 1'b0;
        drive(2'd0, 2'd0, 1'b0, 1'b1, 16'd1000);
        @(negedge clk);
        smp_valid_i = 1'b0;
        chk("R6 strobe sample old data", int'($signed(smp_data_o)), 500);
        chk("R6 strobe sample old ver", int'(ver_o), 'h20);
        @(negedge clk);
        chk("R6 next sample new data", int'($signed(smp_data_o)), 1000);
        chk("R6 next sample new ver", int'(ver_o), 'h21);

        // R7: back-to-back selector change
        @(negedge clk);
        drive(2'd0, 2'd0, 1'b1, 1'b1, 16'd1000);
        @(negedge clk);
        drive(2'd1, 2'd0, 1'b0, 1'b1, 16'd1000);
        @(negedge clk);
        smp_valid_i = 1'b0;
        chk("R7 first data", int'($signed(smp_data_o)), 600);
        chk("R7 first ver", int'(ver_o), 'h11);
        @(negedge clk);
        chk("R7 second valid", int'(smp_valid_o), 1);
        chk("R7 second data", int'($signed(smp_data_o)), 1500);
        chk("R7 second ver", int'(ver_o), 'h13);

        // R9: latency in corrected and bypass modes
        for (int en = 0; en < 2; en++) begin
            @(negedge clk);
            drive(2'd0, 2'd0, 1'b1, 1'(en), 16'd40);
            @(negedge clk);
            smp_valid_i = 1'b0;
            chk("R9 one cycle", int'(smp_valid_o), 0);
            @(negedge clk);
            chk("R9 two cycles", int'(smp_valid_o), 1);
            chk("R9 data", int'($signed(smp_data_o)), en ? 120 : 40);
            @(negedge clk);
            chk("R9 three cycles", int'(smp_valid_o), 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule